// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

This block is a memory-mapped event timer. One free-running 32-bit counter advances once every `PRESCALE` system clocks while the global enable is on. A row of comparator channels watches that counter. When the counter reaches a channel's comparator value, the channel raises an interrupt. It does this either once (one-shot) or repeatedly with an automatic reload period (periodic).

Software reaches every register through a plain 32-bit register port. The port has a select, a write strobe, a byte address and combinational read data. The address map is as follows:

| Offset | Register |
|---|---|
| 0x00 | capabilities (read-only) |
| 0x04 | tick period in femtoseconds (read-only) |
| 0x10 | global control |
| 0x20 | interrupt status (write 1 to clear) |
| 0x30 | main counter |

Channel `n` occupies a 16-byte slot at `0x40 + 16*n`. The slot holds a control word at +0, a read-only route mask at +4 and the comparator at +8. Any other offset reads zero. The default build has at most 12 channels, so that every slot fits the 8-bit address.

Interrupts leave the block on a 32-line route vector. Each channel drives the line chosen by its route field. When legacy steering is on, channel 0 drives line 0 and channel 1 drives line 8 instead.

Top module: `cmp_event_timer`

## Requirements
- R1: After reset the following all read zero: global control, status, main counter and every comparator. All 32 route lines are low.
- R2: The capabilities word is built as follows:
  - bits 31:16 hold `VENDOR`;
  - bit 15 holds `LEGACY_CAP`;
  - bit 13 is 0 (no wide counter);
  - bits 12:8 hold the channel count minus one;
  - bits 7:0 hold `REV`.

  The default value is 0x1D0F8302. The period register returns `PERIOD_FS` (default 100000000, which is 10 MHz). An unmapped offset such as 0x3C reads 0.
- R3: Global control bit 0 enables the counter. While it is set, the counter increments by one every `PRESCALE` clocks, with the first step `PRESCALE` clocks after enable is written. While it is clear, the counter holds its value, and a write to 0x30 loads it.
- R4: A one-shot channel (control bit 3 = 0) fires once when the counter steps onto its comparator value. It does not fire again until the comparator is written again.
- R5: A channel may be periodic (control bit 3 = 1) with value-set (control bit 6, which is write-only) armed. In that case the next comparator write sets the match time and the following comparator write sets the reload period. Each match then adds the period to the comparator.
- R6: Control bit 3 can be set only on a channel with periodic capability, which is read-only bit 4 (default: channels 0 and 1). On any other channel bit 3 reads 0.
- R7: On a level channel (control bit 1 = 1) with interrupt enable (bit 2) set, a match sets that channel's status bit and holds its route line high. Writing 1 to the status bit clears both the bit and the line. Writing 0 to it changes nothing.
- R8: On an edge channel (control bit 1 = 0) with enable set, a match produces exactly one single-cycle pulse on its route line and does not set a status bit.
- R9: The route field sits in control bits 13:9. The channel's route mask, read at slot offset +4 (default 0x00F00000), lists the routes the channel may use. A write naming a route outside that mask leaves the route field unchanged.
- R10: With global control bit 1 set (legacy steering), channel 0 drives line 0 and channel 1 drives line 8, and both ignore their route fields.
- R11: With interrupt enable clear, a match sets no status bit and drives no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write strobe (with select) |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data |
| irq_route_o | output | 32 | Interrupt route lines |

## Verification
Each kind of wrong internal state shows at the ports as follows:
- A corrupted prescaler or enable shows up as a counter value that is off after a known number of clocks, on the very next read.
- A lost periodic reload or value-set phase shows up as a wrong pulse count on the route line and a wrong comparator readback once the counter has passed three match points.
- A status or one-shot arming fault shows up as a line that stays high after clear, or as a second pulse, within one comparator interval.
- A steering fault shows up as pulses counted on the wrong line during the first match after legacy steering is turned on.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned DW = 32;

  localparam logic [7:0] OFS_CAPS   = 8'h00;
  localparam logic [7:0] OFS_PERIOD = 8'h04;
  localparam logic [7:0] OFS_GCTL   = 8'h10;
  localparam logic [7:0] OFS_STAT   = 8'h20;
  localparam logic [7:0] OFS_COUNT  = 8'h30;
  localparam logic [7:0] OFS_CH0    = 8'h40;

  localparam logic [1:0] SLOT_CTL  = 2'd0;
  localparam logic [1:0] SLOT_MASK = 2'd1;
  localparam logic [1:0] SLOT_CMP  = 2'd2;

  localparam int unsigned B_LEVEL  = 1;
  localparam int unsigned B_IE     = 2;
  localparam int unsigned B_PER    = 3;
  localparam int unsigned B_PERCAP = 4;
  localparam int unsigned B_VSET   = 6;
  localparam int unsigned B_F32    = 8;
  localparam int unsigned B_RT_LO  = 9;
  localparam int unsigned RT_W     = 5;
endpackage

// File: rtl/evt_counter.sv
module evt_counter
  import evt_timer_pkg::*;
#(
  parameter int unsigned PRESCALE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  output logic [DW-1:0] cnt,
  output logic          tick
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PMAX = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (pre_q == PMAX);
    pre_d = pre_q;
    if (!en || tick) pre_d = '0;
    else             pre_d = pre_q + 1'b1;
    cnt_d = cnt_q;
    if (ld)        cnt_d = ld_val;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld) |=> $stable(cnt_q));
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
#(
  parameter bit          PER_CAP = 1'b1,
  parameter logic [31:0] RT_MASK = 32'h00F0_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [DW-1:0]   cnt,
  input  logic            ctl_we,
  input  logic            cmp_we,
  input  logic [DW-1:0]   wdata,
  input  logic            stat_clr,
  output logic [DW-1:0]   ctl_rd,
  output logic [DW-1:0]   cmp_rd,
  output logic [RT_W-1:0] route,
  output logic            status,
  output logic            line
);
  logic            level_q, ie_q, per_q, f32_q, vset_q, wantp_q, armed_q;
  logic            level_d, ie_d, per_d, f32_d, vset_d, wantp_d, armed_d;
  logic [RT_W-1:0] rt_q, rt_d;
  logic [DW-1:0]   cmp_q, cmp_d, prd_q, prd_d;
  logic            stat_q, stat_d, pulse_q, pulse_d;
  logic            match;
  logic [RT_W-1:0] rt_req;

  assign rt_req = wdata[B_RT_LO +: RT_W];
  assign match  = tick && armed_q && ((cnt + 1'b1) == cmp_q);

  always_comb begin
    level_d = level_q; ie_d = ie_q; per_d = per_q; f32_d = f32_q;
    vset_d  = vset_q;  wantp_d = wantp_q; armed_d = armed_q; rt_d = rt_q;
    cmp_d   = cmp_q;   prd_d = prd_q;
    if (ctl_we) begin
      level_d = wdata[B_LEVEL];
      ie_d    = wdata[B_IE];
      per_d   = wdata[B_PER] & PER_CAP;
      f32_d   = wdata[B_F32];
      vset_d  = wdata[B_VSET];
      wantp_d = 1'b0;
      if (RT_MASK[rt_req]) rt_d = rt_req;
    end
    if (cmp_we) begin
      armed_d = 1'b1;
      if (per_q && vset_q) begin
        cmp_d   = wdata;
        vset_d  = 1'b0;
        wantp_d = 1'b1;
      end else if (wantp_q) begin
        prd_d   = wdata;
        wantp_d = 1'b0;
      end else begin
        cmp_d   = wdata;
      end
    end else if (match) begin
      if (per_q) cmp_d   = cmp_q + prd_q;
      else       armed_d = 1'b0;
    end
    stat_d  = stat_q;
    if (stat_clr) stat_d = 1'b0;
    if (match && ie_q && level_q) stat_d = 1'b1;
    pulse_d = match && ie_q && !level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0; ie_q <= 1'b0; per_q <= 1'b0; f32_q <= 1'b0;
      vset_q  <= 1'b0; wantp_q <= 1'b0; armed_q <= 1'b0; rt_q <= '0;
      cmp_q   <= '0;   prd_q <= '0; stat_q <= 1'b0; pulse_q <= 1'b0;
    end else begin
      level_q <= level_d; ie_q <= ie_d; per_q <= per_d; f32_q <= f32_d;
      vset_q  <= vset_d;  wantp_q <= wantp_d; armed_q <= armed_d; rt_q <= rt_d;
      cmp_q   <= cmp_d;   prd_q <= prd_d; stat_q <= stat_d; pulse_q <= pulse_d;
    end
  end

  always_comb begin
    ctl_rd = '0;
    ctl_rd[B_LEVEL]           = level_q;
    ctl_rd[B_IE]              = ie_q;
    ctl_rd[B_PER]             = per_q;
    ctl_rd[B_PERCAP]          = PER_CAP;
    ctl_rd[B_F32]             = f32_q;
    ctl_rd[B_RT_LO +: RT_W]   = rt_q;
  end

  assign cmp_rd = cmp_q;
  assign route  = rt_q;
  assign status = stat_q;
  assign line   = level_q ? (stat_q & ie_q) : pulse_q;

  // R4: a one-shot channel does not match again without a new comparator write
  a_r4_once: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !per_q && !cmp_we) |=> !match);
  // R5: a periodic match advances the comparator by the period
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (match && per_q && !cmp_we) |=> (cmp_q == $past(cmp_q) + $past(prd_q)));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !stat_clr) |=> stat_q);
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_q && !stat_q) |=> !stat_q && !pulse_q);
  a_r6_percap: assert property (@(posedge clk) disable iff (!rst_n)
    !PER_CAP |-> !per_q);
endmodule

// File: rtl/cmp_event_timer.sv
module cmp_event_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned N_CH       = 4,
  parameter int unsigned PRESCALE   = 4,
  parameter logic [31:0] PERIOD_FS  = 32'd100_000_000,
  parameter logic [15:0] VENDOR     = 16'h1D0F,
  parameter logic [7:0]  REV        = 8'h02,
  parameter logic [31:0] PER_CAP    = 32'h0000_0003,
  parameter logic [31:0] RT_MASK    = 32'h00F0_0000,
  parameter bit          LEGACY_CAP = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic [31:0] irq_route_o
);
  localparam logic [7:0] CH_END = OFS_CH0 + 8'(N_CH * 16);
  localparam logic [31:0] CAPS  = {VENDOR, LEGACY_CAP, 2'b00, 5'(N_CH - 1), REV};

  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  logic       wr, is_ch, en_q, en_d, leg_q, leg_d;
  logic [7:0] rel;
  logic [3:0] ch_idx;
  logic [1:0] slot;
  logic       tick, tick_eff, cnt_ld;
  logic [DW-1:0] cnt;

  assign wr     = bus_sel_i && bus_we_i;
  assign is_ch  = (bus_addr_i >= OFS_CH0) && (bus_addr_i < CH_END);
  assign rel    = bus_addr_i - OFS_CH0;
  assign ch_idx = rel[7:4];
  assign slot   = rel[3:2];
  assign cnt_ld = wr && (bus_addr_i == OFS_COUNT);

  always_comb begin
    en_d  = en_q;
    leg_d = leg_q;
    if (wr && bus_addr_i == OFS_GCTL) begin
      en_d  = bus_wdata_i[0];
      leg_d = bus_wdata_i[1] & LEGACY_CAP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      leg_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      leg_q <= leg_d;
    end
  end

  evt_counter #(.PRESCALE(PRESCALE)) u_cnt (
    .clk(clk_i), .rst_n(rst_n), .en(en_q), .ld(cnt_ld),
    .ld_val(bus_wdata_i), .cnt(cnt), .tick(tick)
  );
  assign tick_eff = tick && !cnt_ld;

  logic [DW-1:0]   ch_ctl [N_CH];
  logic [DW-1:0]   ch_cmp [N_CH];
  logic [RT_W-1:0] ch_rt  [N_CH];
  logic [N_CH-1:0] ch_stat, ch_line;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic sel_i;
    assign sel_i = wr && is_ch && (ch_idx == 4'(i));
    evt_channel #(.PER_CAP(PER_CAP[i]), .RT_MASK(RT_MASK)) u_ch (
      .clk(clk_i), .rst_n(rst_n), .tick(tick_eff), .cnt(cnt),
      .ctl_we(sel_i && slot == SLOT_CTL), .cmp_we(sel_i && slot == SLOT_CMP),
      .wdata(bus_wdata_i),
      .stat_clr(wr && (bus_addr_i == OFS_STAT) && bus_wdata_i[i]),
      .ctl_rd(ch_ctl[i]), .cmp_rd(ch_cmp[i]), .route(ch_rt[i]),
      .status(ch_stat[i]), .line(ch_line[i])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      if (is_ch) begin
        case (slot)
          SLOT_CTL:  bus_rdata_o = ch_ctl[ch_idx];
          SLOT_MASK: bus_rdata_o = RT_MASK;
          SLOT_CMP:  bus_rdata_o = ch_cmp[ch_idx];
          default:   bus_rdata_o = '0;
        endcase
      end else begin
        case (bus_addr_i)
          OFS_CAPS:   bus_rdata_o = CAPS;
          OFS_PERIOD: bus_rdata_o = PERIOD_FS;
          OFS_GCTL:   bus_rdata_o = {30'd0, leg_q, en_q};
          OFS_STAT:   bus_rdata_o = {{(32-N_CH){1'b0}}, ch_stat};
          OFS_COUNT:  bus_rdata_o = cnt;
          default:    bus_rdata_o = '0;
        endcase
      end
    end
  end

  always_comb begin
    irq_route_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (leg_q && i == 0)        irq_route_o[0] = irq_route_o[0] | ch_line[i];
      else if (leg_q && i == 1)   irq_route_o[8] = irq_route_o[8] | ch_line[i];
      else if (RT_MASK[ch_rt[i]]) irq_route_o[ch_rt[i]] = irq_route_o[ch_rt[i]] | ch_line[i];
    end
  end

  // R10: under legacy steering channel 1 reaches line 8
  a_r10_leg_ch1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (leg_q && ch_line[1]) |-> irq_route_o[8]);
  // R1: counter stays at zero until enabled or loaded after reset
  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!en_q && !cnt_ld && cnt == '0) |=> cnt == '0);
endmodule

// File: tb/cmp_event_timer_tb_top.sv
module cmp_event_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, we;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata, irq;

  always #4 clk = ~clk;

  cmp_event_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_route_o(irq)
  );

  typedef struct { string tag; logic [31:0] val; } item_t;
  item_t       exp_q[$];
  logic [31:0] obs_q[$];
  int n_tests = 0, n_fail = 0;
  int unsigned pc[32];
  bit done = 0;

  initial for (int i = 0; i < 32; i++) pc[i] = 0;
  always @(negedge clk) for (int i = 0; i < 32; i++) if (irq[i] === 1'b1) pc[i]++;

  // monitor: compare observed values against expected items in order
  always @(negedge clk) begin
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      item_t e;
      logic [31:0] o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      n_tests++;
      if (o !== e.val) begin
        n_fail++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", e.tag, o, e.val);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    exp_q.push_back('{tag: tag, val: exp});
    obs_q.push_back(act);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a;
    #1 d = rdata; sel = 0;
  endtask

  task automatic wait_cnt(input logic [31:0] target);
    logic [31:0] c;
    c = 0;
    for (int k = 0; k < 20000 && c < target; k++) rd(8'h30, c);
  endtask

  logic [31:0] v, c;
  int unsigned s0, s8, s20, s21, s23;

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  initial begin
    sel = 0; we = 0; addr = 0; wdata = 0; rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h10, v); chk("R1 gctl", v, 0);
    rd(8'h20, v); chk("R1 status", v, 0);
    rd(8'h30, v); chk("R1 counter", v, 0);
    rd(8'h48, v); chk("R1 cmp0", v, 0);
    chk("R1 lines", irq, 0);

    // R2 identification
    rd(8'h00, v); chk("R2 caps", v, 32'h1D0F_8302);
    rd(8'h04, v); chk("R2 period", v, 32'd100_000_000);
    rd(8'h3C, v); chk("R2 unmapped", v, 0);

    // R3 prescaled count and freeze
    wr(8'h30, 100);
    wr(8'h10, 1);
    repeat (38) @(negedge clk);
    wr(8'h10, 0);
    rd(8'h30, v); chk("R3 ten ticks in 40 clocks", v, 110);
    repeat (20) @(negedge clk);
    rd(8'h30, v); chk("R3 frozen", v, 110);

    // R9 route mask and filtering, R6 periodic capability
    rd(8'h44, v); chk("R9 mask word", v, 32'h00F0_0000);
    wr(8'h60, 32'h0000_0A00);
    rd(8'h60, v); chk("R9 disallowed route ignored", v, 0);
    wr(8'h60, 32'h0000_2A08);
    rd(8'h60, v); chk("R6 periodic not settable ch2", v, 32'h0000_2A00);

    // R4 / R8 one-shot edge on ch2 route 21
    wr(8'h30, 0);
    wr(8'h60, 32'h0000_2A04);
    wr(8'h68, 20);
    s21 = pc[21];
    wr(8'h10, 1);
    wait_cnt(30);
    chk("R8 single pulse", pc[21] - s21, 1);
    rd(8'h20, v); chk("R8 no status for edge", v, 0);
    wait_cnt(60);
    chk("R4 no refire", pc[21] - s21, 1);
    rd(8'h30, c);
    wr(8'h68, c + 10);
    wait_cnt(c + 20);
    chk("R4 rearmed by write", pc[21] - s21, 2);

    // R7 level on ch3 route 22
    wr(8'h70, 32'h0000_2C06);
    rd(8'h70, v); chk("R7 ctl readback", v, 32'h0000_2C06);
    rd(8'h30, c);
    wr(8'h78, c + 8);
    wait_cnt(c + 14);
    @(negedge clk); chk("R7 line held", {31'd0, irq[22]}, 1);
    rd(8'h20, v); chk("R7 status set", v, 8);
    wr(8'h20, 0);
    rd(8'h20, v); chk("R7 write 0 no effect", v, 8);
    @(negedge clk); chk("R7 line still high", {31'd0, irq[22]}, 1);
    wr(8'h20, 8);
    rd(8'h20, v); chk("R7 cleared", v, 0);
    @(negedge clk); chk("R7 line dropped", {31'd0, irq[22]}, 0);

    // R5 periodic with value-set on ch0 route 20
    wr(8'h10, 0);
    wr(8'h30, 0);
    wr(8'h40, 32'h0000_284C);
    rd(8'h40, v); chk("R6 periodic set ch0", v, 32'h0000_281C);
    wr(8'h48, 10);
    wr(8'h48, 25);
    s20 = pc[20];
    wr(8'h10, 1);
    wait_cnt(70);
    wr(8'h10, 0);
    chk("R5 three periodic pulses", pc[20] - s20, 3);
    rd(8'h48, v); chk("R5 comparator advanced", v, 85);

    // R11 disabled interrupt on ch1 route 23
    wr(8'h50, 32'h0000_2E02);
    s23 = pc[23];
    wr(8'h10, 1);
    rd(8'h30, c);
    wr(8'h58, c + 5);
    wait_cnt(c + 10);
    rd(8'h20, v); chk("R11 no status", v & 2, 0);
    chk("R11 no line", pc[23] - s23, 0);

    // R10 legacy steering
    wr(8'h50, 32'h0000_2E04);
    s0 = pc[0]; s8 = pc[8]; s20 = pc[20]; s23 = pc[23];
    wr(8'h10, 3);
    rd(8'h30, c);
    wr(8'h58, c + 6);
    wait_cnt(c + 60);
    wr(8'h10, 0);
    chk("R10 ch1 on line 8", pc[8] - s8, 1);
    chk("R10 ch1 not on route", pc[23] - s23, 0);
    chk("R10 ch0 not on route", pc[20] - s20, 0);
    chk("R10 ch0 on line 0", {31'd0, (pc[0] - s0) >= 2}, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule